// File: doc/BRIEF.md
# Priority Preemptive Interrupt Controller

This block gathers level-sensitive interrupt requests from a configurable number of sources and gives each one a 4-bit priority that software programs. Every cycle it finds the pending source with the highest priority. If that priority is strictly greater than the current priority register, it offers the source's 9-bit vector to the processor. Sources that share the top level are resolved by a fixed rule: the lowest source index wins.

The offer to the processor is a valid/ready stream. `cpu_irq_valid` marks an offer and `cpu_irq_ready` is the processor's acknowledge, so a transfer happens on any clock edge where both are high. The offer is not held while the processor waits. While `cpu_irq_ready` is low, the vector follows the live arbitration result and can switch to a higher source that arrives in the meantime. The transfer takes whatever vector is present on the handshake edge. On each transfer the controller pushes the old current priority onto an internal LIFO and loads the level of the acknowledged source. An end-of-interrupt write pops the LIFO and restores the previous level.

Software can also write the current priority directly. Raising it to the ceiling of a shared resource stops the tasks that share that resource from preempting one another.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source priority is 0, the current priority is 0, the LIFO is empty, `cpu_irq_valid` is 0 and `cpu_irq_vector` is 0.
- R2: Register map on `reg_addr` (ADDR_W bits; the top bit set selects control space):
  - With the top bit clear, an address below NUM_SRC reads and writes the 4-bit priority of that source. Other addresses in this space read 0 and ignore writes.
  - In control space, low offset 0 reads and writes the current priority, and offset 1 is the end-of-interrupt command, which reads 0. Other offsets read 0 and ignore writes.
  - `reg_rdata` is combinational on `reg_addr`.
- R3: A source whose priority is 0 never causes `cpu_irq_valid`, whatever its request line does.
- R4: In the same cycle, `cpu_irq_valid` is high exactly when some source is pending with priority strictly above the current priority and the LIFO is not full.
- R5: While valid, `cpu_irq_vector` is the index of the pending source with the highest priority, zero-extended to 9 bits.
- R6: Among pending sources that share the highest priority, the lowest index is presented.
- R7: On an edge with `cpu_irq_valid` and `cpu_irq_ready` both high, the old current priority is pushed and the current priority becomes the acknowledged source's level, visible from the next cycle.
- R8: An end-of-interrupt write pops the LIFO into the current priority. On an empty LIFO it changes nothing.
- R9: While the LIFO holds STACK_DEPTH entries, `cpu_irq_valid` stays low.
- R10: A write to the current priority takes effect on the next cycle, and it may lower or raise the level. If a handshake happens on the same edge, the handshake wins and the write or end-of-interrupt is discarded.
- R11: `cpu_irq_vector` is 0 whenever `cpu_irq_valid` is low. While ready is low, the vector is not held: a higher source that arrives replaces the offered vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level-sensitive request lines, bit i = source i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data for reg_addr |
| cpu_irq_valid | output | 1 | Interrupt offered to the processor |
| cpu_irq_ready | input | 1 | Processor acknowledge |
| cpu_irq_vector | output | 9 | Vector of the offered source |

## Verification
The bench builds the controller with 20 sources and a LIFO depth of 3. Twenty sources is not a power of two, so the arbitration tree carries padded leaves that must never win. A depth of 3 lets a short nesting sequence fill the LIFO, which brings the full-stack blocking rule and the restore order during unwinding within reach. A behavioural model with a queue-based stack predicts the valid flag, the vector and the read data on every cycle, across directed nesting and ceiling sequences and a long random phase.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 9;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] lvl;
    logic [VEC_W-1:0]  idx;
  } cand_t;

  // left operand always covers lower source indices, so it keeps ties
  function automatic cand_t pick(cand_t a, cand_t b);
    if (!b.valid) return a;
    if (!a.valid) return b;
    if (b.lvl > a.lvl) return b;
    return a;
  endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = $clog2(NUM_SRC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] lvl [NUM_SRC],
  output logic [PRIO_W-1:0] rd_src
);
  logic src_space;
  assign src_space = !addr[ADDR_W-1];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic hit;
    assign hit = src_space && (addr == ADDR_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)        lvl[k] <= '0;
      else if (we && hit) lvl[k] <= wdata;
    end
  end

  always_comb begin
    rd_src = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if (src_space && addr == ADDR_W'(k)) rd_src = lvl[k];
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [PRIO_W-1:0]  lvl [NUM_SRC],
  output cand_t              win
);
  localparam int LEAVES = 1 << $clog2(NUM_SRC);
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < NUM_SRC) begin : g_real
      assign node[LEAVES-1+j] = '{valid: req[j] && (lvl[j] != '0),
                                  lvl:   lvl[j],
                                  idx:   VEC_W'(j)};
    end else begin : g_pad
      assign node[LEAVES-1+j] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    assign node[n] = pick(node[2*n+1], node[2*n+2]);
  end

  assign win = node[0];
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_val,
  output logic [PRIO_W-1:0] top_val,
  output logic              empty,
  output logic              full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PRIO_W-1:0] slot [DEPTH];
  logic [CW-1:0]     cnt;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [PRIO_W-1:0] below, above;
    if (k == 0) begin : g_first
      assign below = push_val;
    end else begin : g_mid
      assign below = slot[k-1];
    end
    if (k == DEPTH - 1) begin : g_last
      assign above = '0;
    end else begin : g_up
      assign above = slot[k+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    slot[k] <= '0;
      else if (push) slot[k] <= below;
      else if (pop)  slot[k] <= above;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (push) cnt <= cnt + 1'b1;
    else if (pop)  cnt <= cnt - 1'b1;
  end

  assign top_val = slot[0];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 24,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = $clog2(NUM_SRC) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [PRIO_W-1:0]  reg_wdata,
  output logic [PRIO_W-1:0]  reg_rdata,
  output logic               cpu_irq_valid,
  input  logic               cpu_irq_ready,
  output logic [VEC_W-1:0]   cpu_irq_vector
);
  localparam int IW = $clog2(NUM_SRC);
  localparam logic [ADDR_W-2:0] OFF_CPR = '0;
  localparam logic [ADDR_W-2:0] OFF_EOI = (ADDR_W-1)'(1);

  logic [PRIO_W-1:0] lvl [NUM_SRC];
  logic [PRIO_W-1:0] rd_src, stk_top, cpr_q;
  logic              stk_empty, stk_full;
  cand_t             win;
  logic              ctrl_sel, hs, cpr_wr, eoi;
  logic [ADDR_W-2:0] ctrl_off;
  logic [IW-1:0]     win_src;

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .lvl(lvl), .rd_src(rd_src));

  prio_irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req(irq_src), .lvl(lvl), .win(win));

  assign ctrl_sel = reg_addr[ADDR_W-1];
  assign ctrl_off = reg_addr[ADDR_W-2:0];
  assign win_src  = win.idx[IW-1:0];

  assign cpu_irq_valid  = win.valid && (win.lvl > cpr_q) && !stk_full;
  assign cpu_irq_vector = cpu_irq_valid ? win.idx : '0;
  assign hs             = cpu_irq_valid && cpu_irq_ready;

  // a handshake on the same edge discards software priority commands
  assign cpr_wr = reg_we && ctrl_sel && (ctrl_off == OFF_CPR) && !hs;
  assign eoi    = reg_we && ctrl_sel && (ctrl_off == OFF_EOI) && !hs && !stk_empty;

  prio_irq_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(hs), .pop(eoi), .push_val(cpr_q),
    .top_val(stk_top), .empty(stk_empty), .full(stk_full));

  always_ff @(posedge clk) begin
    if (!rst_n)      cpr_q <= '0;
    else if (hs)     cpr_q <= win.lvl;
    else if (eoi)    cpr_q <= stk_top;
    else if (cpr_wr) cpr_q <= reg_wdata;
  end

  always_comb begin
    if (ctrl_sel) reg_rdata = (ctrl_off == OFF_CPR) ? cpr_q : '0;
    else          reg_rdata = rd_src;
  end

  assert_valid_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_valid |-> (irq_src[win_src] && lvl[win_src] > cpr_q));
  assert_level0_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_valid |-> (lvl[win_src] != '0));
  assert_ack_loads_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (cpr_q == $past(lvl[win_src])));
  assert_eoi_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> (cpr_q == $past(stk_top)));
  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !cpu_irq_valid);
  assert_cpr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpr_wr |=> (cpr_q == $past(reg_wdata)));
  assert_vector_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq_valid |-> (cpu_irq_vector == '0));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int N  = 20;
  localparam int D  = 3;
  localparam int AW = $clog2(N) + 1;
  localparam logic [AW-1:0] CTRL = AW'(1) << (AW - 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  src = '0;
  logic          we = 0, ready = 0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    wdata = '0;
  logic [3:0]    rdata;
  logic          valid;
  logic [8:0]    vector;

  prio_irq_ctrl #(.NUM_SRC(N), .STACK_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .cpu_irq_valid(valid),
    .cpu_irq_ready(ready), .cpu_irq_vector(vector));

  always #10 clk = ~clk;

  int    errors = 0, checks = 0;
  bit    done = 0;
  string tag = "R1";
  int    mprio [N];
  int    mcpr;
  int    mstk [$];
  bit    ev;
  int    ei, el;

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_now();
    int er;
    ev = 0; ei = 0; el = 0;
    for (int i = 0; i < N; i++)
      if (src[i] && mprio[i] > mcpr && mprio[i] > el) begin
        ev = 1; ei = i; el = mprio[i];
      end
    if (mstk.size() >= D) ev = 0;
    if (addr[AW-1]) er = (addr[AW-2:0] == 0) ? mcpr : 0;
    else            er = (int'(addr) < N) ? mprio[addr] : 0;
    cmp("valid", valid, ev);
    cmp("vector", vector, ev ? ei : 0);
    cmp("rdata", rdata, er);
  endtask

  // called at a negedge with inputs set; returns at the next negedge
  task automatic tick();
    #5 check_now();
    @(posedge clk);
    if (ev && ready) begin
      mstk.push_back(mcpr);
      mcpr = el;
    end else if (we && addr[AW-1]) begin
      if (addr[AW-2:0] == 0) mcpr = wdata;
      else if (addr[AW-2:0] == 1 && mstk.size() > 0) mcpr = mstk.pop_back();
    end
    if (we && !addr[AW-1] && int'(addr) < N) mprio[addr] = wdata;
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    addr = a; tick();
  endtask

  task automatic ack();
    ready = 1; tick(); ready = 0;
  endtask

  task automatic eoi();
    wr(CTRL | AW'(1), 4'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mprio[i] = 0;
    mcpr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, with a few sources pending at priority 0
    tag = "R1"; tick(); src = 20'h00ff0; tick(); rd(CTRL);
    // R2: program and read back every source priority and control space
    tag = "R2"; src = '0;
    for (int i = 0; i < N; i++) wr(AW'(i), (i % 5 == 0) ? 4'd0 : 4'(((i * 7) % 15) + 1));
    for (int i = 0; i < N; i++) rd(AW'(i));
    wr(AW'(25), 4'd9); rd(AW'(25));
    wr(CTRL | AW'(2), 4'd7); rd(CTRL | AW'(2)); rd(CTRL | AW'(1)); rd(CTRL);
    // R3: only zero-priority sources pending
    tag = "R3"; src = '0; src[0] = 1; src[5] = 1; src[10] = 1; src[15] = 1; tick(); tick();
    // R4 / R5: mixed pending patterns
    tag = "R4"; src = 20'h0000a; tick(); src = 20'h00300; tick();
    tag = "R5"; src = '1; tick(); src = 20'h55555; tick(); src = 20'haaaa0; tick();
    // R6: tie at the same level
    tag = "R6"; wr(AW'(6), 4'd9); wr(AW'(9), 4'd9); wr(AW'(11), 4'd9);
    src = '0; src[9] = 1; src[6] = 1; src[11] = 1; tick(); src[6] = 0; tick();
    // R7 / R9 / R10 / R8: nesting until the stack is full, then unwinding
    tag = "R7"; wr(AW'(1), 4'd5); wr(AW'(2), 4'd10); wr(AW'(3), 4'd15);
    src = '0; src[1] = 1; tick(); ack(); tick();
    src[2] = 1; tick(); ack(); tick(); rd(CTRL);
    tag = "R10"; wr(CTRL, 4'd0); tick();
    tag = "R9"; src[3] = 1; ack(); tick(); wr(CTRL, 4'd0); tick(); ack(); tick();
    tag = "R8"; eoi(); tick(); rd(CTRL); eoi(); rd(CTRL); eoi(); rd(CTRL);
    eoi(); rd(CTRL); eoi(); rd(CTRL);
    // R10: ceiling write, then ack in the same cycle as a write
    tag = "R10"; src = '0; src[1] = 1; src[2] = 1; wr(CTRL, 4'd8); tick();
    wr(CTRL, 4'd12); tick(); wr(CTRL, 4'd0); tick();
    we = 1; addr = CTRL; wdata = 4'd12; ready = 1; tick(); we = 0; ready = 0;
    rd(CTRL); eoi(); rd(CTRL);
    // R11: vector follows a higher arrival while ready is low
    tag = "R11"; src = '0; src[1] = 1; tick(); src[3] = 1; tick(); ack(); rd(CTRL);
    eoi(); src = '0; tick();
    // random phase
    tag = "R5";
    for (int c = 0; c < 1500; c++) begin
      int r;
      src = N'($urandom);
      ready = ($urandom % 4 == 0);
      r = $urandom % 10;
      we = (r < 4);
      if (r < 2)       begin addr = AW'($urandom % N); wdata = 4'($urandom); end
      else if (r == 2) begin addr = CTRL; wdata = 4'($urandom % 12); end
      else if (r == 3) begin addr = CTRL | AW'(1); wdata = 4'd0; end
      else             addr = ($urandom % 2) ? CTRL : AW'($urandom % N);
      tick();
    end
    we = 0; ready = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule